// File: doc/BRIEF.md
# Bit-Reversed Address Sequencer

This block produces the bit-reversed visiting order for an in-place radix-2 FFT reorder. After a load pulse that captures the transform size as a base-two exponent, it presents address 0. It then moves to the next address in the sequence on every clock in which the advance enable is high. The address for linear index i is the lowest log2N bits of i written in reverse order. Two of these sequencers are meant to be driven by the same enable: one supplies read addresses and one supplies write-back addresses for the swap. They stay in lockstep because each one depends only on its own load and enable.

The generator uses no index counter. The sequence is built up stage by stage. Stage 0 covers indices 0 and 1, and stage k (k >= 1) covers indices 2^k up to 2^(k+1)-1. Every address in stage k is an address from an earlier stage plus the weight N >> (k+1). A one-hot register holds that weight. A mask register marks the address bits above it, where a reverse-direction carry steps through the earlier addresses. Both registers shift right once when a stage completes. The mask shift is arithmetic and the one-hot shift is logical. The offset register is updated through a subtract/add pair whose two terms come from the correction logic.

The enable works like a consumer ready signal. The address is held for as long as the enable is low, so the consumer can stall for any number of cycles and no address is lost.

Top module: `brev_addr_gen`

## Requirements
- R1: After reset, addr_o is 0, done_o is 0 and stage_done_o is 0. adv_en_i has no effect until the first load.
- R2: A cycle with start_i high captures log2n_i, which must be in the range 2 to AW. From the next cycle addr_o is 0 and done_o is 0, and this holds even if a previous run had finished.
- R3: While a run is active, the address shown for linear index i is the log2N-bit reversal of i. Index 0 is shown right after the load, and each clock with adv_en_i high moves to index i+1.
- R4: In an active run, a clock with adv_en_i low leaves addr_o unchanged, and stage_done_o stays low during it.
- R5: stage_done_o is high, combinationally, exactly during an advancing cycle whose current index i satisfies i >= 1 with i+1 a power of two. This gives log2N pulses per run.
- R6: The advance from index N-1 sets done_o. After that, addr_o holds N-1 and adv_en_i has no effect until the next load.
- R7: When start_i and adv_en_i are high in the same cycle, the load wins. No advance happens and stage_done_o stays low in that cycle.
- R8: The one-hot weight register starts at N/2 and the mask register starts with ones at every position at or above log2N. At each completed stage, except the last, the one-hot register shifts right logically and the mask shifts right arithmetically, so the mask's lowest one always sits just above the one-hot bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load pulse; captures log2n_i and restarts at index 0 |
| log2n_i | input | $clog2(AW+1) | Transform size exponent, 2..AW |
| adv_en_i | input | 1 | Advance to the next address this clock |
| addr_o | output | AW | Current bit-reversed address |
| stage_done_o | output | 1 | This advance completes a stage |
| done_o | output | 1 | Sequence finished; address held |

## Verification
Two things can happen in the same cycle: a load pulse and an advance request. The collision that matters most is one where the advance would have closed a stage. The bench stops a 64-point run just before index 3, where stage 1 ends, and raises both start_i and adv_en_i in that cycle. It checks that stage_done_o stays low in that cycle and that the next address is 0 with done_o clear. A full run from index 0 then confirms the reloaded state. Before and after the collision, random enable patterns are checked index by index against a bit-reverse computed in the bench.

// File: rtl/brev_pkg.sv
package brev_pkg;
  // Run phase of the sequencer
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } brev_phase_e;
endpackage

// File: rtl/brev_stage_regs.sv
// Per-stage pattern registers: a mask of upper ones and a one-hot weight.
module brev_stage_regs #(
  parameter int AW = 8,
  parameter int LW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [LW-1:0] log2n_i,
  input  logic          shift_i,
  output logic [AW:0]   mask_o,
  output logic [AW-1:0] onehot_o
);
  logic [AW:0]   mask_q;
  logic [AW-1:0] onehot_q;
  logic [AW:0]   low_ones;

  // ones below bit log2n; extra top bit keeps the mask non-empty when log2n == AW
  assign low_ones = ({{AW{1'b0}}, 1'b1} << log2n_i) - {{AW{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      onehot_q <= '0;
    end else if (load_i) begin
      mask_q   <= ~low_ones;
      onehot_q <= {{(AW-1){1'b0}}, 1'b1} << (log2n_i - LW'(1));
    end else if (shift_i) begin
      mask_q   <= {mask_q[AW], mask_q[AW:1]};
      onehot_q <= onehot_q >> 1;
    end
  end

  assign mask_o   = mask_q;
  assign onehot_o = onehot_q;

  // R8
  onehot_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(onehot_q));
  // R8
  mask_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[AW]);
  // R8
  mask_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (onehot_q != '0) |-> (((mask_q[AW-1:0] & onehot_q) == '0) &&
                          (({onehot_q, 1'b0} & mask_q) != '0)));
endmodule

// File: rtl/brev_step_logic.sv
// Correction generation: subtract and add terms for the next offset.
module brev_step_logic #(
  parameter int AW = 8,
  parameter int LW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW:0]   mask_i,
  input  logic [AW-1:0] onehot_i,
  input  logic [LW-1:0] log2n_i,
  output logic [AW-1:0] next_o,
  output logic          stage_end_o,
  output logic          last_o
);
  logic [AW-1:0] sub_t;
  logic [AW-1:0] add_t;
  logic          carry;
  logic          has_top;

  always_comb begin
    sub_t   = '0;
    add_t   = '0;
    carry   = 1'b1;
    has_top = |(addr_i & onehot_i);
    // reverse-direction carry over the bits above the current weight
    for (int b = AW - 1; b >= 0; b--) begin
      if (mask_i[b] && (b < int'(log2n_i)) && carry) begin
        if (addr_i[b]) begin
          sub_t[b] = 1'b1;
        end else begin
          add_t[b] = 1'b1;
          carry    = 1'b0;
        end
      end
    end
    if (!has_top) begin
      sub_t = '0;
      add_t = onehot_i;
    end else if (carry) begin
      sub_t = addr_i;
      add_t = onehot_i >> 1;
    end
    next_o      = addr_i - sub_t + add_t;
    stage_end_o = has_top && carry;
    last_o      = has_top && carry && onehot_i[0];
  end
endmodule

// File: rtl/brev_addr_gen.sv
module brev_addr_gen #(
  parameter int AW = 8,
  parameter int LW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] log2n_i,
  input  logic          adv_en_i,
  output logic [AW-1:0] addr_o,
  output logic          stage_done_o,
  output logic          done_o
);
  import brev_pkg::*;

  brev_phase_e   phase_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] log2n_q;
  logic [AW:0]   mask;
  logic [AW-1:0] onehot;
  logic [AW-1:0] next_addr;
  logic          stage_end;
  logic          last;
  logic          adv;

  assign adv = adv_en_i && (phase_q == PH_RUN) && !start_i;

  brev_stage_regs #(.AW(AW), .LW(LW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_i),
    .log2n_i  (log2n_i),
    .shift_i  (adv && stage_end && !last),
    .mask_o   (mask),
    .onehot_o (onehot)
  );

  brev_step_logic #(.AW(AW), .LW(LW)) u_step (
    .addr_i      (addr_q),
    .mask_i      (mask),
    .onehot_i    (onehot),
    .log2n_i     (log2n_q),
    .next_o      (next_addr),
    .stage_end_o (stage_end),
    .last_o      (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      log2n_q <= '0;
    end else if (start_i) begin
      phase_q <= PH_RUN;
      addr_q  <= '0;
      log2n_q <= log2n_i;
    end else if (adv) begin
      if (last) phase_q <= PH_DONE;
      else      addr_q  <= next_addr;
    end
  end

  assign addr_o       = addr_q;
  assign stage_done_o = adv && stage_end;
  assign done_o       = (phase_q == PH_DONE);

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> ({1'b0, addr_q} < ({{AW{1'b0}}, 1'b1} << log2n_q)));
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && !adv_en_i && !start_i) |=> $stable(addr_o));
  // R6
  final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(addr_o)));
  // R7
  start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !stage_done_o);
  // R2
  load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (addr_o == '0 && !done_o));
  // R5
  stage_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done_o |-> (adv_en_i && !done_o));
endmodule

// File: tb/brev_addr_gen_bench.sv
module brev_addr_gen_bench;
  localparam int AW = 8;
  localparam int LW = $clog2(AW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] log2n = '0;
  logic          adv = 1'b0;
  logic [AW-1:0] addr;
  logic          stage_done;
  logic          done;

  int checks = 0;
  int fails  = 0;
  int idx    = 0;

  always #5 clk = ~clk;

  brev_addr_gen #(.AW(AW), .LW(LW)) u_brev_addr_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .log2n_i      (log2n),
    .adv_en_i     (adv),
    .addr_o       (addr),
    .stage_done_o (stage_done),
    .done_o       (done)
  );

  function automatic int rev(int v, int l);
    int r = 0;
    for (int b = 0; b < l; b++) if (v[b]) r |= (1 << (l - 1 - b));
    return r;
  endfunction

  function automatic bit ends_stage(int i);
    return (i >= 1) && ((i & (i + 1)) == 0);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(int l);
    @(negedge clk);
    start = 1'b1; log2n = LW'(l); adv = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(addr == 0, "R2 addr after load", int'(addr), 0);
    chk(done == 1'b0, "R2 done after load", int'(done), 0);
    idx = 0;
  endtask

  // advance with random enable until index reaches stop_at (R3, R4, R5, R8)
  task automatic run_to(int l, int pct, int stop_at);
    while (idx < stop_at) begin
      @(negedge clk);
      adv = (($urandom % 100) < pct);
      #1;
      chk(int'(addr) == rev(idx, l), "R3 address", int'(addr), rev(idx, l));
      if (adv)
        chk(stage_done == ends_stage(idx), "R5 stage flag", int'(stage_done), int'(ends_stage(idx)));
      else
        chk(stage_done == 1'b0, "R4 stall flag", int'(stage_done), 0);
      @(posedge clk);
      if (adv) idx++;
    end
    @(negedge clk);
    adv = 1'b0;
  endtask

  task automatic full_run(int l, int pct);
    do_load(l);
    run_to(l, pct, 1 << l);
    #1;
    chk(done == 1'b1, "R6 done set", int'(done), 1);
    chk(int'(addr) == (1 << l) - 1, "R6 last held", int'(addr), (1 << l) - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    #1;
    chk(addr == 0, "R1 reset addr", int'(addr), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // enable before any load is ignored (R1)
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      adv = 1'b1;
      #1;
      chk(stage_done == 1'b0, "R1 idle flag", int'(stage_done), 0);
      chk(addr == 0, "R1 idle addr", int'(addr), 0);
      chk(done == 1'b0, "R1 idle done", int'(done), 0);
    end

    // N = 8 with enable always high
    full_run(3, 100);
    // enable after done has no effect (R6)
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      adv = 1'b1;
      #1;
      chk(stage_done == 1'b0, "R6 flag after done", int'(stage_done), 0);
      @(negedge clk);
      #1;
      chk(addr == 7, "R6 addr after done", int'(addr), 7);
      chk(done == 1'b1, "R6 done kept", int'(done), 1);
    end

    // N = 16 with gaps, reload after done clears it (R2)
    full_run(4, 60);

    // N = 64: stop before index 3 (stage end), collide load with advance (R7)
    do_load(6);
    run_to(6, 70, 3);
    start = 1'b1; log2n = LW'(6); adv = 1'b1;
    #1;
    chk(stage_done == 1'b0, "R7 no flag on load", int'(stage_done), 0);
    chk(int'(addr) == rev(3, 6), "R7 addr before edge", int'(addr), rev(3, 6));
    @(negedge clk);
    start = 1'b0; adv = 1'b0;
    #1;
    chk(addr == 0, "R7 load wins", int'(addr), 0);
    chk(done == 1'b0, "R7 done clear", int'(done), 0);
    idx = 0;
    run_to(6, 75, 64);
    #1;
    chk(done == 1'b1, "R6 done N64", int'(done), 1);

    // smallest and largest sizes
    full_run(2, 50);
    full_run(AW, 85);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule